// File: doc/BRIEF.md
# Bus-Master DMA Sequencer

This block is the back-end engine that feeds the master side of a 32-bit PCI master core. That core never inserts wait states, so the engine keeps data moving through two FIFOs. Software loads a source address for bus reads, a destination address for bus writes, a length in dwords for each direction, and a control word. Setting a start bit marks a job as pending. The engine then chooses one pending direction, raises the matching mode line, and raises the bus request once its FIFO can supply or take data. After that, every data strobe from the core moves one dword: the engine steps the address by 4 and counts the job and the burst down.

A non-zero burst length splits a job into bus bursts of at most that many dwords. A burst length of zero runs the whole job as one burst. The engine warns the core when one dword, and when two or fewer dwords, remain in the current burst. At the end of each burst it keeps mode and request asserted until the core reports that its pipeline has drained. It then arbitrates again. A target abort or a target timeout stops the job and sets an error bit. Done and error bits can each raise the interrupt.

Top module: `dma_seq_top`

## Requirements
- R1: Reset state. After reset every output is 0. This includes both modes, the request, both flags, both FIFO strobes, both addresses, the read command and the interrupt. Every register reads as zero.
- R2: Register map, by word offset.
  - 0: read address.
  - 1: write address.
  - 2: lengths in dwords. Read length is in [15:0] and write length is in [31:16].
  - 3: control. Burst length is in [7:0]. Start-read is bit 8 and start-write is bit 9; both read back 0. Read priority is bit 10. Done-interrupt enable is bit 11 and error-interrupt enable is bit 12. The read command is in [14:13].
  - 4: status. Read busy is bit 0 and write busy is bit 1. Read done is bit 2 and write done is bit 3. Read error is bit 4 and write error is bit 5.
  - The address and length registers read back the engine's live values.
- R3: A mode line rises when a burst starts. It stays high until the core reports done for that same direction. The read mode and the write mode are never high together.
- R4: The request rises only while data is available. For writes, the outgoing FIFO must not be empty. For reads, the incoming FIFO must not be full. Once raised, the request holds until the burst ends.
- R5: The active address grows by exactly 4 on each transferred dword and is otherwise stable. The job length falls by one on each transferred dword.
- R6: The one-left flag is high exactly when one dword remains in the current burst. The two-or-fewer flag is high exactly when one or two remain. Both flags are low outside the data phase of a burst.
- R7: The outgoing FIFO pop equals the core's data-accepted strobe during a write burst. The incoming FIFO push equals the core's data-valid strobe during a read burst. Neither strobe fires at any other time.
- R8: The read command output equals control field [14:13]. The codes are 00 or 01 for a plain read, 10 for a line read, and 11 for a multiple read.
- R9: A burst length of N, where N is not zero, gives bursts of min(N, remaining) dwords until the job is finished. A burst length of 0 gives a single burst.
- R10: A target abort or a target timeout during a burst has the following effects:
  - the mode line drops on the next cycle;
  - the busy bit clears and the error bit sets, while the done bit stays clear;
  - the address and length registers keep the progress already made.
- R11: When both jobs are pending, grants alternate between the two directions. After a read grant, the write wins the next tie, and the reverse. With read priority set, a pending read always wins.
- R12: Writing 1 to a status done or error bit clears it. Writing 0 leaves the bit unchanged. The interrupt is the OR of the enabled done bits and the enabled error bits.
- R13: A job started with length 0 sets its done bit without raising any mode line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read word offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| ofifo_empty | input | 1 | Outgoing (write) FIFO empty |
| ofifo_pop | output | 1 | Pop of the outgoing FIFO |
| ififo_full | input | 1 | Incoming (read) FIFO full |
| ififo_push | output | 1 | Push of the incoming FIFO |
| mst_rd_mode | output | 1 | Read burst in progress |
| mst_wr_mode | output | 1 | Write burst in progress |
| mst_req | output | 1 | Bus request to the core |
| mst_one_left | output | 1 | One dword left in the burst |
| mst_two_left | output | 1 | Two or fewer dwords left in the burst |
| mst_rd_addr | output | ADDR_W | Current read address |
| mst_wr_addr | output | ADDR_W | Current write address |
| mst_rd_cmd | output | 2 | Read command code |
| core_wr_accept | input | 1 | Core took one write dword |
| core_rd_valid | input | 1 | Core delivers one read dword |
| core_wr_done | input | 1 | Write pipeline drained |
| core_rd_done | input | 1 | Read pipeline drained |
| core_tabort | input | 1 | Target abort seen |
| core_timeout | input | 1 | Target timeout seen |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases, each with the failure it would expose:

- Burst splitting with a remainder (5 dwords in bursts of 2). A design that miscounts either repeats a dword or flags the last dword one cycle off.
- A FIFO that is empty or full at the start of a burst. A request that ignores it would show up while mode is high and data is missing.
- Tie-breaking in both arbitration modes. Wrong pointer handling shows up as a repeated direction in the recorded burst order.
- Abort and timeout in the middle of a burst. A wrong design might leave the mode stuck, set done, or lose the partial address and length.
- A zero-length job. A design that gets it wrong raises a mode line and waits forever for data.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int unsigned DATA_W = 32;

    // register word offsets
    localparam logic [2:0] OFS_RADDR = 3'd0;
    localparam logic [2:0] OFS_WADDR = 3'd1;
    localparam logic [2:0] OFS_LEN   = 3'd2;
    localparam logic [2:0] OFS_CTRL  = 3'd3;
    localparam logic [2:0] OFS_STAT  = 3'd4;

    // control bit positions
    localparam int unsigned CB_GO_RD   = 8;
    localparam int unsigned CB_GO_WR   = 9;
    localparam int unsigned CB_PRIO    = 10;
    localparam int unsigned CB_IE_DONE = 11;
    localparam int unsigned CB_IE_ERR  = 12;
    localparam int unsigned CB_CMD_LO  = 13;

    // status bit positions
    localparam int unsigned SB_RD_BUSY = 0;
    localparam int unsigned SB_WR_BUSY = 1;
    localparam int unsigned SB_RD_DONE = 2;
    localparam int unsigned SB_WR_DONE = 3;
    localparam int unsigned SB_RD_ERR  = 4;
    localparam int unsigned SB_WR_ERR  = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } seq_dir_e;

endpackage

// File: rtl/dma_seq_arb.sv
module dma_seq_arb (
    input  logic rd_pend,
    input  logic wr_pend,
    input  logic rd_prio,
    input  logic last_wr,
    output logic grant_vld,
    output logic grant_wr
);
    always_comb begin
        grant_vld = rd_pend | wr_pend;
        if (rd_pend && wr_pend) begin
            grant_wr = rd_prio ? 1'b0 : ~last_wr;
        end else begin
            grant_wr = wr_pend;
        end
    end
endmodule

// File: rtl/dma_seq_flags.sv
module dma_seq_flags #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             active,
    input  logic [CNT_W-1:0] left,
    output logic             one_left,
    output logic             two_left
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    always_comb begin
        one_left = active && (left == ONE);
        two_left = active && (left != '0) && (left <= TWO);
    end
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
    import dma_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned BL_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [2:0]        reg_rd_addr,
    output logic [31:0]       reg_rdata,
    input  logic              ofifo_empty,
    output logic              ofifo_pop,
    input  logic              ififo_full,
    output logic              ififo_push,
    output logic              mst_rd_mode,
    output logic              mst_wr_mode,
    output logic              mst_req,
    output logic              mst_one_left,
    output logic              mst_two_left,
    output logic [ADDR_W-1:0] mst_rd_addr,
    output logic [ADDR_W-1:0] mst_wr_addr,
    output logic [1:0]        mst_rd_cmd,
    input  logic              core_wr_accept,
    input  logic              core_rd_valid,
    input  logic              core_wr_done,
    input  logic              core_rd_done,
    input  logic              core_tabort,
    input  logic              core_timeout,
    output logic              irq
);
    localparam int unsigned WLEN_LO = DATA_W / 2;
    localparam logic [ADDR_W-1:0] DWORD_STEP = ADDR_W'(4);
    localparam logic [LEN_W-1:0]  LEN_ONE    = LEN_W'(1);

    typedef struct packed {
        seq_state_e        st;
        seq_dir_e          dir;
        logic              req;
        logic              last_wr;
        logic [ADDR_W-1:0] rd_addr;
        logic [ADDR_W-1:0] wr_addr;
        logic [LEN_W-1:0]  rd_len;
        logic [LEN_W-1:0]  wr_len;
        logic [LEN_W-1:0]  bcnt;
        logic [BL_W-1:0]   blen;
        logic              rd_prio;
        logic              ie_done;
        logic              ie_err;
        logic [1:0]        rd_cmd;
        logic              rd_busy;
        logic              wr_busy;
        logic              rd_done;
        logic              wr_done;
        logic              rd_err;
        logic              wr_err;
    } seq_regs_t;

    seq_regs_t q, d;

    logic grant_vld, grant_wr;
    logic data_phase;
    logic xfer_wr, xfer_rd, xfer;
    logic avail, drained, fault;

    function automatic logic [LEN_W-1:0] burst_size(input logic [LEN_W-1:0] len,
                                                    input logic [BL_W-1:0]  bl);
        if (bl == '0 || len <= LEN_W'(bl)) begin
            return len;
        end
        return LEN_W'(bl);
    endfunction

    dma_seq_arb u_arb (
        .rd_pend   (q.rd_busy && q.st == ST_IDLE),
        .wr_pend   (q.wr_busy && q.st == ST_IDLE),
        .rd_prio   (q.rd_prio),
        .last_wr   (q.last_wr),
        .grant_vld (grant_vld),
        .grant_wr  (grant_wr)
    );

    dma_seq_flags #(.CNT_W(LEN_W)) u_flags (
        .active   (data_phase),
        .left     (q.bcnt),
        .one_left (mst_one_left),
        .two_left (mst_two_left)
    );

    always_comb begin
        data_phase = (q.st == ST_BURST);
        xfer_wr    = data_phase && q.dir == DIR_WR && q.req && core_wr_accept;
        xfer_rd    = data_phase && q.dir == DIR_RD && q.req && core_rd_valid;
        xfer       = xfer_wr | xfer_rd;
        avail      = (q.dir == DIR_WR) ? ~ofifo_empty : ~ififo_full;
        drained    = (q.dir == DIR_WR) ? core_wr_done : core_rd_done;
        fault      = core_tabort | core_timeout;
    end

    always_comb begin
        d = q;

        // software access
        if (reg_wr_en) begin
            unique case (reg_wr_addr)
                OFS_RADDR: d.rd_addr = reg_wdata[ADDR_W-1:0];
                OFS_WADDR: d.wr_addr = reg_wdata[ADDR_W-1:0];
                OFS_LEN: begin
                    d.rd_len = reg_wdata[LEN_W-1:0];
                    d.wr_len = reg_wdata[WLEN_LO +: LEN_W];
                end
                OFS_CTRL: begin
                    d.blen    = reg_wdata[BL_W-1:0];
                    d.rd_prio = reg_wdata[CB_PRIO];
                    d.ie_done = reg_wdata[CB_IE_DONE];
                    d.ie_err  = reg_wdata[CB_IE_ERR];
                    d.rd_cmd  = reg_wdata[CB_CMD_LO +: 2];
                    if (reg_wdata[CB_GO_RD]) d.rd_busy = 1'b1;
                    if (reg_wdata[CB_GO_WR]) d.wr_busy = 1'b1;
                end
                OFS_STAT: begin
                    if (reg_wdata[SB_RD_DONE]) d.rd_done = 1'b0;
                    if (reg_wdata[SB_WR_DONE]) d.wr_done = 1'b0;
                    if (reg_wdata[SB_RD_ERR])  d.rd_err  = 1'b0;
                    if (reg_wdata[SB_WR_ERR])  d.wr_err  = 1'b0;
                end
                default: ;
            endcase
        end

        // sequencing
        unique case (q.st)
            ST_IDLE: begin
                if (grant_vld) begin
                    d.last_wr = grant_wr;
                    if (grant_wr) begin
                        if (q.wr_len == '0) begin
                            d.wr_busy = 1'b0;
                            d.wr_done = 1'b1;
                        end else begin
                            d.st   = ST_BURST;
                            d.dir  = DIR_WR;
                            d.bcnt = burst_size(q.wr_len, q.blen);
                        end
                    end else begin
                        if (q.rd_len == '0) begin
                            d.rd_busy = 1'b0;
                            d.rd_done = 1'b1;
                        end else begin
                            d.st   = ST_BURST;
                            d.dir  = DIR_RD;
                            d.bcnt = burst_size(q.rd_len, q.blen);
                        end
                    end
                end
            end
            ST_BURST: begin
                if (!q.req && avail) begin
                    d.req = 1'b1;
                end
                if (xfer) begin
                    d.bcnt = q.bcnt - LEN_ONE;
                    if (q.dir == DIR_WR) begin
                        d.wr_addr = q.wr_addr + DWORD_STEP;
                        d.wr_len  = q.wr_len - LEN_ONE;
                    end else begin
                        d.rd_addr = q.rd_addr + DWORD_STEP;
                        d.rd_len  = q.rd_len - LEN_ONE;
                    end
                    if (q.bcnt == LEN_ONE) begin
                        d.st = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (drained) begin
                    d.st  = ST_IDLE;
                    d.req = 1'b0;
                    if (q.dir == DIR_WR && q.wr_len == '0) begin
                        d.wr_busy = 1'b0;
                        d.wr_done = 1'b1;
                    end
                    if (q.dir == DIR_RD && q.rd_len == '0) begin
                        d.rd_busy = 1'b0;
                        d.rd_done = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // abort or timeout ends the job
        if (q.st != ST_IDLE && fault) begin
            d.st  = ST_IDLE;
            d.req = 1'b0;
            if (q.dir == DIR_WR) begin
                d.wr_busy = 1'b0;
                d.wr_err  = 1'b1;
            end else begin
                d.rd_busy = 1'b0;
                d.rd_err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_rd_addr)
            OFS_RADDR: reg_rdata[ADDR_W-1:0] = q.rd_addr;
            OFS_WADDR: reg_rdata[ADDR_W-1:0] = q.wr_addr;
            OFS_LEN: begin
                reg_rdata[LEN_W-1:0]         = q.rd_len;
                reg_rdata[WLEN_LO +: LEN_W]  = q.wr_len;
            end
            OFS_CTRL: begin
                reg_rdata[BL_W-1:0]          = q.blen;
                reg_rdata[CB_PRIO]           = q.rd_prio;
                reg_rdata[CB_IE_DONE]        = q.ie_done;
                reg_rdata[CB_IE_ERR]         = q.ie_err;
                reg_rdata[CB_CMD_LO +: 2]    = q.rd_cmd;
            end
            OFS_STAT: begin
                reg_rdata[SB_RD_BUSY] = q.rd_busy;
                reg_rdata[SB_WR_BUSY] = q.wr_busy;
                reg_rdata[SB_RD_DONE] = q.rd_done;
                reg_rdata[SB_WR_DONE] = q.wr_done;
                reg_rdata[SB_RD_ERR]  = q.rd_err;
                reg_rdata[SB_WR_ERR]  = q.wr_err;
            end
            default: ;
        endcase
    end

    always_comb begin
        mst_rd_mode = (q.st != ST_IDLE) && q.dir == DIR_RD;
        mst_wr_mode = (q.st != ST_IDLE) && q.dir == DIR_WR;
        mst_req     = q.req;
        mst_rd_addr = q.rd_addr;
        mst_wr_addr = q.wr_addr;
        mst_rd_cmd  = q.rd_cmd;
        ofifo_pop   = xfer_wr;
        ififo_push  = xfer_rd;
        irq         = (q.ie_done && (q.rd_done || q.wr_done))
                    || (q.ie_err && (q.rd_err || q.wr_err));
    end

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic              mst_rd_mode,
    input logic              mst_wr_mode,
    input logic              mst_req,
    input logic              mst_one_left,
    input logic              mst_two_left,
    input logic              ofifo_pop,
    input logic              ififo_push,
    input logic [ADDR_W-1:0] mst_wr_addr,
    input logic [ADDR_W-1:0] mst_rd_addr,
    input logic              core_wr_done,
    input logic              core_rd_done,
    input logic              core_tabort,
    input logic              core_timeout
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    // R3: only one direction at a time
    assert_mode_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mst_rd_mode && mst_wr_mode));

    // R3: write mode held until drained
    assert_wr_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_wr_mode && !core_wr_done && !core_tabort && !core_timeout) |=> mst_wr_mode);

    // R3: read mode held until drained
    assert_rd_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_rd_mode && !core_rd_done && !core_tabort && !core_timeout) |=> mst_rd_mode);

    // R4: request held until the burst ends
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && !core_wr_done && !core_rd_done && !core_tabort && !core_timeout) |=> mst_req);

    // R5: write address steps by one dword per pop
    assert_wr_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ofifo_pop && !reg_wr_en) |=> (mst_wr_addr == $past(mst_wr_addr) + STEP));

    // R5: read address steps by one dword per push
    assert_rd_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ififo_push && !reg_wr_en) |=> (mst_rd_addr == $past(mst_rd_addr) + STEP));

    // R5: address stable without a transfer
    assert_wr_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ofifo_pop && !reg_wr_en) |=> $stable(mst_wr_addr));

    // R6: one left implies two or fewer left
    assert_flag_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mst_one_left |-> mst_two_left);

    // R7: strobes only inside a requested burst of the right direction
    assert_pop_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ofifo_pop |-> (mst_wr_mode && mst_req));
    assert_push_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ififo_push |-> (mst_rd_mode && mst_req));

    // R10: a fault ends the burst on the next cycle
    assert_fault_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mst_wr_mode || mst_rd_mode) && (core_tabort || core_timeout))
            |=> !(mst_wr_mode || mst_rd_mode));

endmodule

bind dma_seq_top dma_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .mst_rd_mode  (mst_rd_mode),
    .mst_wr_mode  (mst_wr_mode),
    .mst_req      (mst_req),
    .mst_one_left (mst_one_left),
    .mst_two_left (mst_two_left),
    .ofifo_pop    (ofifo_pop),
    .ififo_push   (ififo_push),
    .mst_wr_addr  (mst_wr_addr),
    .mst_rd_addr  (mst_rd_addr),
    .core_wr_done (core_wr_done),
    .core_rd_done (core_rd_done),
    .core_tabort  (core_tabort),
    .core_timeout (core_timeout)
);

// File: tb/dma_seq_top_tb_top.sv
`timescale 1ns/1ps
module dma_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_rd_addr = '0;
    logic [31:0] reg_rdata;
    logic        ofifo_empty = 1'b0;
    logic        ofifo_pop;
    logic        ififo_full = 1'b0;
    logic        ififo_push;
    logic        mst_rd_mode, mst_wr_mode, mst_req, mst_one_left, mst_two_left;
    logic [31:0] mst_rd_addr, mst_wr_addr;
    logic [1:0]  mst_rd_cmd;
    logic        core_wr_accept = 1'b0;
    logic        core_rd_valid = 1'b0;
    logic        core_wr_done = 1'b0;
    logic        core_rd_done = 1'b0;
    logic        core_tabort = 1'b0;
    logic        core_timeout = 1'b0;
    logic        irq;

    always #5 clk = ~clk;

    dma_seq_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wdata(reg_wdata),
        .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
        .ofifo_empty(ofifo_empty), .ofifo_pop(ofifo_pop),
        .ififo_full(ififo_full), .ififo_push(ififo_push),
        .mst_rd_mode(mst_rd_mode), .mst_wr_mode(mst_wr_mode), .mst_req(mst_req),
        .mst_one_left(mst_one_left), .mst_two_left(mst_two_left),
        .mst_rd_addr(mst_rd_addr), .mst_wr_addr(mst_wr_addr), .mst_rd_cmd(mst_rd_cmd),
        .core_wr_accept(core_wr_accept), .core_rd_valid(core_rd_valid),
        .core_wr_done(core_wr_done), .core_rd_done(core_rd_done),
        .core_tabort(core_tabort), .core_timeout(core_timeout),
        .irq(irq)
    );

    int total = 0;
    int bad = 0;

    // behavioural reference state, index 0 = read, 1 = write
    logic [31:0] m_addr [2];
    int          m_len  [2];
    int          m_bl = 0;
    int          burst_rem = 0;
    int          drain = 0;
    int          xfer_cnt = 0;
    int          inj_at = -1;
    bit          inj_timeout = 1'b0;
    bit          exp_drop = 1'b0;
    int          exp_drop_dir = 0;
    bit          prev_rd = 1'b0;
    bit          prev_wr = 1'b0;
    int          order_q [$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // core emulator and cycle comparison
    always @(negedge clk) begin
        if (!rst_n) begin
            core_wr_accept <= 1'b0;
        end else begin
            int  dir;
            bit  act;
            act = mst_rd_mode || mst_wr_mode;
            dir = mst_wr_mode ? 1 : 0;
            check("R3 exclusive modes", {31'd0, mst_rd_mode && mst_wr_mode}, 32'd0);
            if (exp_drop) begin
                check("R3/R10 mode drops", {31'd0, exp_drop_dir == 1 ? mst_wr_mode : mst_rd_mode}, 32'd0);
                exp_drop = 1'b0;
            end
            if ((mst_wr_mode && !prev_wr) || (mst_rd_mode && !prev_rd)) begin
                order_q.push_back(dir);
                burst_rem = (m_bl == 0 || m_len[dir] <= m_bl) ? m_len[dir] : m_bl;
                drain = 0;
                xfer_cnt = 0;
            end
            if (act) begin
                check("R5 address", dir == 1 ? mst_wr_addr : mst_rd_addr, m_addr[dir]);
                check("R6 one left", {31'd0, mst_one_left}, {31'd0, burst_rem == 1});
                check("R6 two left", {31'd0, mst_two_left}, {31'd0, burst_rem >= 1 && burst_rem <= 2});
            end else begin
                check("R6 flags idle", {30'd0, mst_one_left, mst_two_left}, 32'd0);
            end
            prev_rd = mst_rd_mode;
            prev_wr = mst_wr_mode;
            core_wr_accept = 1'b0; core_rd_valid = 1'b0;
            core_wr_done = 1'b0;   core_rd_done = 1'b0;
            core_tabort = 1'b0;    core_timeout = 1'b0;
            if (act && inj_at >= 0 && xfer_cnt == inj_at && mst_req) begin
                if (inj_timeout) core_timeout = 1'b1; else core_tabort = 1'b1;
                inj_at = -1;
                exp_drop = 1'b1; exp_drop_dir = dir;
                burst_rem = 0;
            end else if (act && burst_rem > 0 && mst_req) begin
                if (dir == 1) core_wr_accept = 1'b1; else core_rd_valid = 1'b1;
                m_addr[dir] = m_addr[dir] + 32'd4;
                m_len[dir]  = m_len[dir] - 1;
                burst_rem   = burst_rem - 1;
                xfer_cnt    = xfer_cnt + 1;
            end else if (act && burst_rem == 0 && !exp_drop) begin
                drain++;
                if (drain == 2) begin
                    if (dir == 1) core_wr_done = 1'b1; else core_rd_done = 1'b1;
                    exp_drop = 1'b1; exp_drop_dir = dir;
                end
            end
            #1;
            check("R7 pop follows accept", {31'd0, ofifo_pop}, {31'd0, core_wr_accept});
            check("R7 push follows valid", {31'd0, ififo_push}, {31'd0, core_rd_valid});
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr_addr = a; reg_wdata = v; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        reg_rd_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input int bl, input bit go_rd, input bit go_wr,
                                        input bit prio, input bit ie_d, input bit ie_e,
                                        input logic [1:0] cmd);
        return {17'd0, cmd, ie_e, ie_d, prio, go_wr, go_rd, bl[7:0]};
    endfunction

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            #2;
            reg_read(3'd4, s);
            if (s[1:0] == 2'b00 && !mst_rd_mode && !mst_wr_mode) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] ra, input logic [31:0] wa, input int rl, input int wl);
        reg_write(3'd0, ra); m_addr[0] = ra;
        reg_write(3'd1, wa); m_addr[1] = wa;
        reg_write(3'd2, {wl[15:0], rl[15:0]}); m_len[0] = rl; m_len[1] = wl;
    endtask

    task automatic check_order(input string tag, input int base, input int exp []);
        check({tag, " burst count"}, order_q.size() - base, exp.size());
        for (int i = 0; i < exp.size(); i++) begin
            if (base + i < order_q.size()) check(tag, order_q[base + i], exp[i]);
        end
    endtask

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        m_addr[0] = '0; m_addr[1] = '0; m_len[0] = 0; m_len[1] = 0;
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        check("R1 outputs", {mst_rd_mode, mst_wr_mode, mst_req, mst_one_left, mst_two_left,
                             ofifo_pop, ififo_push, irq, mst_rd_cmd}, 32'd0);
        check("R1 addresses", mst_rd_addr | mst_wr_addr, 32'd0);
        for (int a = 0; a < 5; a++) begin
            reg_read(a[2:0], v);
            check("R1 register zero", v, 32'd0);
        end
        @(negedge clk); rst_n = 1'b1;

        // R2 register map readback
        setup(32'hA000_0010, 32'hB000_0020, 7, 9);
        reg_write(3'd3, ctl(8'h35, 0, 0, 1, 1, 0, 2'b10));
        reg_read(3'd0, v); check("R2 read addr", v, 32'hA000_0010);
        reg_read(3'd1, v); check("R2 write addr", v, 32'hB000_0020);
        reg_read(3'd2, v); check("R2 lengths", v, 32'h0009_0007);
        reg_read(3'd3, v); check("R2 control", v, 32'h0000_4C35);
        check("R8 read command", {30'd0, mst_rd_cmd}, 32'd2);
        reg_read(3'd4, v); check("R2 status idle", v, 32'd0);

        // write job 5 dwords, bursts of 2; out FIFO empty at start (R4, R9)
        base = order_q.size();
        ofifo_empty = 1'b1;
        setup(32'h0, 32'h0000_1000, 0, 5);
        m_bl = 2;
        reg_write(3'd3, ctl(2, 0, 1, 0, 1, 1, 2'b00));
        #2; reg_read(3'd4, v); check("R2 write busy", v & 32'h3, 32'h2);
        while (!mst_wr_mode) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #2;
            check("R4 no request without data", {31'd0, mst_req}, 32'd0);
        end
        ofifo_empty = 1'b0;
        wait_idle();
        check_order("R9 split bursts", base, '{1, 1, 1});
        reg_read(3'd1, v); check("R5 final write addr", v, 32'h0000_1014);
        reg_read(3'd2, v); check("R5 write length consumed", v[31:16], 32'd0);
        reg_read(3'd4, v); check("R12 write done", v, 32'h0000_0008);
        check("R12 irq on done", {31'd0, irq}, 32'd1);
        reg_write(3'd4, 32'h0000_0034);
        #2; reg_read(3'd4, v); check("R12 write zero keeps bit", v, 32'h0000_0008);
        reg_write(3'd4, 32'h0000_0008);
        #2; reg_read(3'd4, v); check("R12 w1c clears", v, 32'd0);
        check("R12 irq cleared", {31'd0, irq}, 32'd0);

        // read job 4 dwords unlimited; in FIFO full at start (R4, R8, R9)
        base = order_q.size();
        ififo_full = 1'b1;
        setup(32'h0000_2000, 32'h0000_1014, 4, 0);
        m_bl = 0;
        reg_write(3'd3, ctl(0, 1, 0, 0, 1, 1, 2'b11));
        while (!mst_rd_mode) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); #2;
            check("R4 no read request when full", {31'd0, mst_req}, 32'd0);
        end
        check("R8 read multiple code", {30'd0, mst_rd_cmd}, 32'd3);
        ififo_full = 1'b0;
        wait_idle();
        check_order("R9 unlimited single burst", base, '{0});
        reg_read(3'd0, v); check("R5 final read addr", v, 32'h0000_2010);
        reg_read(3'd4, v); check("R12 read done", v, 32'h0000_0004);
        reg_write(3'd4, 32'h0000_0004);

        // round robin, both pending, bursts of 1 (R11)
        base = order_q.size();
        setup(32'h0000_3000, 32'h0000_4000, 2, 2);
        m_bl = 1;
        reg_write(3'd3, ctl(1, 1, 1, 0, 0, 0, 2'b00));
        wait_idle();
        check_order("R11 round robin", base, '{1, 0, 1, 0});
        reg_write(3'd4, 32'h0000_003C);

        // read priority (R11)
        base = order_q.size();
        setup(32'h0000_5000, 32'h0000_6000, 2, 2);
        reg_write(3'd3, ctl(1, 1, 1, 1, 0, 0, 2'b00));
        wait_idle();
        check_order("R11 read priority", base, '{0, 0, 1, 1});
        reg_write(3'd4, 32'h0000_003C);

        // target abort mid-burst on a write (R10)
        setup(32'h0000_7000, 32'h0000_8000, 0, 6);
        m_bl = 0;
        inj_at = 2; inj_timeout = 1'b0;
        reg_write(3'd3, ctl(0, 0, 1, 0, 0, 1, 2'b00));
        wait_idle();
        reg_read(3'd4, v); check("R10 write error status", v, 32'h0000_0020);
        check("R12 irq on error", {31'd0, irq}, 32'd1);
        reg_read(3'd1, v); check("R10 partial write addr", v, 32'h0000_8008);
        reg_read(3'd2, v); check("R10 partial write length", v[31:16], 32'd4);
        reg_write(3'd4, 32'h0000_0020);
        #2; check("R12 irq after error clear", {31'd0, irq}, 32'd0);

        // target timeout on a read (R10)
        setup(32'h0000_9000, 32'h0000_8008, 3, 0);
        inj_at = 1; inj_timeout = 1'b1;
        reg_write(3'd3, ctl(0, 1, 0, 0, 1, 1, 2'b00));
        wait_idle();
        reg_read(3'd4, v); check("R10 read error status", v, 32'h0000_0010);
        reg_read(3'd0, v); check("R10 partial read addr", v, 32'h0000_9004);
        reg_write(3'd4, 32'h0000_0010);

        // zero-length write job (R13)
        base = order_q.size();
        setup(32'h0, 32'h0000_A000, 0, 0);
        reg_write(3'd3, ctl(4, 0, 1, 0, 1, 0, 2'b00));
        wait_idle();
        check("R13 no burst", order_q.size() - base, 32'd0);
        reg_read(3'd4, v); check("R13 done set", v, 32'h0000_0008);
        reg_read(3'd1, v); check("R13 address untouched", v, 32'h0000_A000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule